// File: doc/BRIEF.md
# Accelerator Handshake Sequencer

This block takes over the bit-level control dialogue of an image-processing accelerator so that host software no longer polls status registers. The accelerator receives commands on single-bit outputs and reports its progress on single-bit inputs. The sequencer watches those inputs and answers each one in the required order:

- it issues a start command once the engine says it is ready;
- it forwards input bytes while the engine asks for data;
- it issues a fetch command once results are available;
- it moves 32-bit results into an output FIFO;
- it closes the segment, or the whole image, when the engine reports completion.

Each image is processed as twelve segments. The block walks through all of them and then waits for the engine to become ready for the next image.

Bytes come from a first-word-fall-through input FIFO, described by its head byte and an empty flag. The block pops a byte only when it forwards it. Results go to an output FIFO and are written only while that FIFO is not full. The result source is told in the same cycle that its word was taken. A segment index and a state code are brought out for observation.

Top module: `accel_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block returns to the wait-for-ready state: `state_o` = 0, `seg_idx_o` = 0, and no command pulse, pop or push follows.
- R2: `acc_start_o` is high for exactly one cycle, in the cycle after a rising edge where the state was wait-for-ready and `acc_ready_i` was high. A high `acc_ready_i` in any other state produces no start.
- R3: `in_pop_o` is high only in the feed state with `acc_req_i` high and the FIFO non-empty. `acc_din_o` then carries `in_data_i`, and `acc_din_vld_o` equals `in_pop_o`. Bytes reach the engine in FIFO order, each exactly once.
- R4: When the input FIFO is empty in the feed state, no pop occurs. Feeding resumes with the next byte once data arrives, with nothing dropped or repeated.
- R5: `acc_give_o` is a one-cycle pulse in the cycle after a rising edge where the state was feed and `acc_res_rdy_i` was high. The state is then drain. There is exactly one pulse per segment.
- R6: In the drain state, a result is pushed (`out_push_o` = `acc_res_take_o` = 1, `out_data_o` = `acc_res_i`) exactly when `acc_res_vld_i` is high and `out_full_i` is low. No push ever happens while `out_full_i` is high.
- R7: In the drain state, `acc_seg_done_i` without `acc_img_done_i` moves the block to wait-for-request and increments `seg_idx_o` by one.
- R8: In the drain state, `acc_seg_done_i` with `acc_img_done_i` moves the block to wait-for-ready and clears `seg_idx_o` to 0.
- R9: An image spans 12 segments: `seg_idx_o` takes the values 0 to 11 and never exceeds 11.
- R10: `state_o` encodes 0 = wait-for-ready, 1 = wait-for-request, 2 = feed, 3 = drain. The block leaves wait-for-request for feed at the first edge where `acc_req_i` is high.
- R11: In the cycle where results-ready is sampled in the feed state, a pending byte is still popped and forwarded. A result pushed in the same cycle as segment-done is still written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_data_i | input | 8 | Head byte of the input FIFO |
| in_empty_i | input | 1 | Input FIFO empty flag |
| in_pop_o | output | 1 | Pop the input FIFO head |
| acc_din_o | output | 8 | Byte forwarded to the engine |
| acc_din_vld_o | output | 1 | Forwarded byte is valid |
| acc_ready_i | input | 1 | Engine ready for a new image |
| acc_req_i | input | 1 | Engine requests input data |
| acc_res_rdy_i | input | 1 | Engine has results ready |
| acc_seg_done_i | input | 1 | Engine finished the segment |
| acc_img_done_i | input | 1 | Engine finished the image (qualifies segment-done) |
| acc_res_i | input | 32 | Result word from the engine |
| acc_res_vld_i | input | 1 | Result word valid |
| acc_res_take_o | output | 1 | Result word accepted this cycle |
| acc_start_o | output | 1 | Start command pulse |
| acc_give_o | output | 1 | Fetch-results command pulse |
| out_data_o | output | 32 | Word written to the output FIFO |
| out_push_o | output | 1 | Output FIFO write strobe |
| out_full_i | input | 1 | Output FIFO full flag |
| seg_idx_o | output | 4 | Current segment index |
| state_o | output | 2 | Current state code |

## Verification
Two pairs of events can fall in the same cycle. In the first pair, the last byte of a segment is popped in the same cycle that results-ready is sampled. The bench provokes this by raising results-ready while one byte is still queued and data is still requested. It then judges the result by the pulse on the fetch command together with a byte count that includes that last byte. In the second pair, the final result of a segment arrives together with segment-done, both for an ordinary segment and for the image-closing one. The scoreboard must receive that word, and the state and segment index must advance in the same step.

// File: rtl/accel_seq_pkg.sv
// Package: shared types for the accelerator handshake sequencer.
// Assumes nothing beyond a two-bit state code seen by the outside world.
package accel_seq_pkg;

    // Sequencer phases; the encoding is observable on state_o.
    typedef enum logic [1:0] {
        ST_WAIT_RDY = 2'd0,   // wait for engine ready, then start
        ST_WAIT_REQ = 2'd1,   // wait for the engine to ask for data
        ST_FEED     = 2'd2,   // forward bytes until results are ready
        ST_DRAIN    = 2'd3    // move results until segment done
    } seq_state_t;

endpackage

// File: rtl/accel_seq_fsm.sv
// Module: accel_seq_fsm
// Phase controller. It steps through wait-for-ready, wait-for-request,
// feed and drain, and issues the registered one-cycle start and fetch
// pulses. It also raises the combinational advance and clear strobes
// for the segment counter.
// Assumes: response inputs are synchronous to clk and the reset is
// synchronous and active low.
module accel_seq_fsm
    import accel_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ready_i,
    input  logic       req_i,
    input  logic       res_rdy_i,
    input  logic       seg_done_i,
    input  logic       img_done_i,
    output seq_state_t state_o,
    output logic       start_o,
    output logic       give_o,
    output logic       seg_adv_o,
    output logic       seg_clr_o
);

    seq_state_t state_q;
    seq_state_t state_d;
    logic       start_d;
    logic       give_d;

    // Next-state and pulse decode for the handshake sequence.
    always_comb begin
        state_d = state_q;
        start_d = 1'b0;
        give_d  = 1'b0;
        unique case (state_q)
            ST_WAIT_RDY: if (ready_i) begin
                state_d = ST_WAIT_REQ;
                start_d = 1'b1;
            end
            ST_WAIT_REQ: if (req_i) begin
                state_d = ST_FEED;
            end
            ST_FEED: if (res_rdy_i) begin
                state_d = ST_DRAIN;
                give_d  = 1'b1;
            end
            ST_DRAIN: if (seg_done_i) begin
                state_d = img_done_i ? ST_WAIT_RDY : ST_WAIT_REQ;
            end
            default: state_d = ST_WAIT_RDY;
        endcase
    end

    // State and command-pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT_RDY;
            start_o <= 1'b0;
            give_o  <= 1'b0;
        end else begin
            state_q <= state_d;
            start_o <= start_d;
            give_o  <= give_d;
        end
    end

    // Segment counter strobes, valid in the cycle segment-done is seen.
    always_comb begin
        seg_adv_o = (state_q == ST_DRAIN) && seg_done_i && !img_done_i;
        seg_clr_o = (state_q == ST_DRAIN) && seg_done_i &&  img_done_i;
    end

    assign state_o = state_q;

    // R2
    start_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> $past(state_q == ST_WAIT_RDY && ready_i));

    // R2
    start_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

    // R5
    give_after_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        give_o |-> ($past(state_q == ST_FEED && res_rdy_i) && state_q == ST_DRAIN));

    // R7
    seg_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN && seg_done_i && !img_done_i) |=> state_q == ST_WAIT_REQ);

    // R10
    feed_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_REQ && req_i) |=> state_q == ST_FEED);

endmodule

// File: rtl/accel_seq_segcnt.sv
// Module: accel_seq_segcnt
// Segment index counter. It advances once per finished segment and
// clears when the image is finished. It wraps after the last segment as
// a guard, so the index always stays inside the image.
// Assumes: adv_i and clr_i are never high together.
module accel_seq_segcnt #(
    parameter  int SEGS  = 12,
    localparam int CNT_W = $clog2(SEGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] idx_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(SEGS - 1);

    logic [CNT_W-1:0] idx_q;

    // Counter update: clear wins, then advance with wrap at the last segment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (clr_i) begin
            idx_q <= '0;
        end else if (adv_i) begin
            idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
        end
    end

    assign idx_o = idx_q;

    // R9
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= LAST);

    // R8
    idx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> idx_q == '0);

endmodule

// File: rtl/accel_seq_inpath.sv
// Module: accel_seq_inpath
// Input steering. In the feed phase it pops the first-word-fall-through
// input FIFO whenever the engine requests data and a byte is present, and
// it forwards that byte in the same cycle.
// Assumes: in_data_i is the valid FIFO head whenever in_empty_i is low.
module accel_seq_inpath
    import accel_seq_pkg::*;
#(
    parameter int IN_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  seq_state_t      state_i,
    input  logic            req_i,
    input  logic            in_empty_i,
    input  logic [IN_W-1:0] in_data_i,
    output logic            in_pop_o,
    output logic [IN_W-1:0] din_o,
    output logic            din_vld_o
);

    // Pop decision: feed phase, data requested, byte available.
    always_comb begin
        in_pop_o  = (state_i == ST_FEED) && req_i && !in_empty_i;
        din_vld_o = in_pop_o;
        din_o     = in_data_i;
    end

    // R4
    no_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_pop_o |-> !in_empty_i);

endmodule

// File: rtl/accel_seq_outpath.sv
// Module: accel_seq_outpath
// Result steering. In the drain phase it passes each valid result word
// to the output FIFO when that FIFO has room, and it acknowledges the
// word to the engine in the same cycle.
// Assumes: out_full_i is current in the cycle the push is decided.
module accel_seq_outpath
    import accel_seq_pkg::*;
#(
    parameter int OUT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  seq_state_t       state_i,
    input  logic             res_vld_i,
    input  logic [OUT_W-1:0] res_i,
    input  logic             out_full_i,
    output logic             take_o,
    output logic             push_o,
    output logic [OUT_W-1:0] data_o
);

    // Transfer decision: drain phase, valid word, room in the FIFO.
    always_comb begin
        take_o = (state_i == ST_DRAIN) && res_vld_i && !out_full_i;
        push_o = take_o;
        data_o = res_i;
    end

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> !out_full_i);

endmodule

// File: rtl/accel_seq.sv
// Module: accel_seq (top)
// Accelerator handshake sequencer. It ties together the phase
// controller, the segment counter and the input and result steering,
// and it exposes the segment index and the state code.
// Assumes: the engine raises image-done only together with segment-done
// on the last segment of an image.
module accel_seq
    import accel_seq_pkg::*;
#(
    parameter  int IN_W  = 8,
    parameter  int OUT_W = 32,
    parameter  int SEGS  = 12,
    localparam int CNT_W = $clog2(SEGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IN_W-1:0]  in_data_i,
    input  logic             in_empty_i,
    output logic             in_pop_o,
    output logic [IN_W-1:0]  acc_din_o,
    output logic             acc_din_vld_o,
    input  logic             acc_ready_i,
    input  logic             acc_req_i,
    input  logic             acc_res_rdy_i,
    input  logic             acc_seg_done_i,
    input  logic             acc_img_done_i,
    input  logic [OUT_W-1:0] acc_res_i,
    input  logic             acc_res_vld_i,
    output logic             acc_res_take_o,
    output logic             acc_start_o,
    output logic             acc_give_o,
    output logic [OUT_W-1:0] out_data_o,
    output logic             out_push_o,
    input  logic             out_full_i,
    output logic [CNT_W-1:0] seg_idx_o,
    output logic [1:0]       state_o
);

    seq_state_t state;
    logic       seg_adv;
    logic       seg_clr;

    accel_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ready_i    (acc_ready_i),
        .req_i      (acc_req_i),
        .res_rdy_i  (acc_res_rdy_i),
        .seg_done_i (acc_seg_done_i),
        .img_done_i (acc_img_done_i),
        .state_o    (state),
        .start_o    (acc_start_o),
        .give_o     (acc_give_o),
        .seg_adv_o  (seg_adv),
        .seg_clr_o  (seg_clr)
    );

    accel_seq_segcnt #(.SEGS(SEGS)) u_segcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .adv_i (seg_adv),
        .clr_i (seg_clr),
        .idx_o (seg_idx_o)
    );

    accel_seq_inpath #(.IN_W(IN_W)) u_inpath (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_i    (state),
        .req_i      (acc_req_i),
        .in_empty_i (in_empty_i),
        .in_data_i  (in_data_i),
        .in_pop_o   (in_pop_o),
        .din_o      (acc_din_o),
        .din_vld_o  (acc_din_vld_o)
    );

    accel_seq_outpath #(.OUT_W(OUT_W)) u_outpath (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_i    (state),
        .res_vld_i  (acc_res_vld_i),
        .res_i      (acc_res_i),
        .out_full_i (out_full_i),
        .take_o     (acc_res_take_o),
        .push_o     (out_push_o),
        .data_o     (out_data_o)
    );

    assign state_o = state;

    // R3
    pop_only_feed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_pop_o |-> (state == ST_FEED && acc_req_i));

    // R8
    img_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN && acc_seg_done_i && acc_img_done_i)
        |=> (state == ST_WAIT_RDY && seg_idx_o == '0));

    // R6
    push_only_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_push_o |-> state == ST_DRAIN);

endmodule

// File: tb/accel_seq_bench.sv
module accel_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int SEGS       = 12;
    localparam int NBYTES     = 4;
    localparam int NRES       = 3;
    localparam int WATCHDOG   = 50000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  in_data;
    logic        in_empty;
    logic        in_pop;
    logic [7:0]  acc_din;
    logic        acc_din_vld;
    logic        acc_ready = 1'b0;
    logic        acc_req = 1'b0;
    logic        acc_res_rdy = 1'b0;
    logic        acc_seg_done = 1'b0;
    logic        acc_img_done = 1'b0;
    logic [31:0] acc_res = '0;
    logic        acc_res_vld = 1'b0;
    logic        acc_res_take;
    logic        acc_start;
    logic        acc_give;
    logic [31:0] out_data;
    logic        out_push;
    logic        out_full = 1'b0;
    logic [3:0]  seg_idx;
    logic [1:0]  state;

    int n_chk = 0;
    int n_fail = 0;
    int byte_cnt = 0;
    int res_cnt = 0;
    int n_start = 0;
    int n_give = 0;
    int wrp = 0;
    int rdp = 0;
    bit done = 1'b0;
    logic [7:0]  fifo_mem [256];
    logic [7:0]  exp_bytes [$];
    logic [31:0] exp_res [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    // Input FIFO model: first-word-fall-through view of the byte store.
    assign in_empty = (wrp == rdp);
    assign in_data  = fifo_mem[rdp[7:0]];

    accel_seq u_accel_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_data_i      (in_data),
        .in_empty_i     (in_empty),
        .in_pop_o       (in_pop),
        .acc_din_o      (acc_din),
        .acc_din_vld_o  (acc_din_vld),
        .acc_ready_i    (acc_ready),
        .acc_req_i      (acc_req),
        .acc_res_rdy_i  (acc_res_rdy),
        .acc_seg_done_i (acc_seg_done),
        .acc_img_done_i (acc_img_done),
        .acc_res_i      (acc_res),
        .acc_res_vld_i  (acc_res_vld),
        .acc_res_take_o (acc_res_take),
        .acc_start_o    (acc_start),
        .acc_give_o     (acc_give),
        .out_data_o     (out_data),
        .out_push_o     (out_push),
        .out_full_i     (out_full),
        .seg_idx_o      (seg_idx),
        .state_o        (state)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push_byte(input logic [7:0] b);
        fifo_mem[wrp[7:0]] = b;
        wrp++;
        exp_bytes.push_back(b);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Monitor: scoreboard compare of forwarded bytes and pushed results.
    always @(posedge clk) begin
        if (rst_n === 1'b1) begin
            chk(acc_din_vld == in_pop, "R3", "din valid vs pop", acc_din_vld, in_pop);
            if (in_pop) begin
                if (exp_bytes.size() == 0)
                    chk(1'b0, "R3", "unexpected byte", acc_din, 0);
                else
                    chk(acc_din == exp_bytes[0], "R3", "byte order", acc_din, exp_bytes[0]);
                if (exp_bytes.size() != 0) void'(exp_bytes.pop_front());
                rdp++;
                byte_cnt++;
            end
            if (out_push) begin
                chk(!out_full, "R6", "push while full", out_full, 0);
                if (exp_res.size() == 0)
                    chk(1'b0, "R6", "unexpected result", out_data, 0);
                else
                    chk(out_data == exp_res[0], "R6", "result word", out_data, exp_res[0]);
                if (exp_res.size() != 0) void'(exp_res.pop_front());
                res_cnt++;
            end
            if (acc_start) n_start++;
            if (acc_give)  n_give++;
        end
    end

    // Segment scenario: 0 normal, 1 starved input, 2 last byte with
    // results-ready, 3 last result with segment-done.
    task automatic run_seg(input int img, input int s, input int mode);
        int base;
        int rbase;
        int tries;
        bit took;
        bit last_seg;
        last_seg = (s == SEGS - 1);
        if (last_seg) acc_ready = 1'b0;
        chk(seg_idx == s[3:0], "R9", "segment index at start", seg_idx, s);
        chk(state == 2'd1, "R10", "wait-for-request code", state, 1);
        base = byte_cnt;
        for (int j = 0; j < ((mode == 1) ? 2 : NBYTES); j++)
            push_byte(8'h5A ^ {img[1:0], s[3:0], j[1:0]});
        @(negedge clk);
        chk(byte_cnt == base && !in_pop, "R3", "no pop without request", byte_cnt - base, 0);
        acc_req = 1'b1;
        if (mode == 1) begin
            repeat (6) @(negedge clk);
            chk(byte_cnt == base + 2, "R4", "bytes before starve", byte_cnt - base, 2);
            chk(!in_pop, "R4", "pop while empty", in_pop, 0);
            for (int j = 2; j < NBYTES; j++)
                push_byte(8'h5A ^ {img[1:0], s[3:0], j[1:0]});
        end
        if (mode == 2) begin
            while (byte_cnt < base + NBYTES - 1) @(negedge clk);
            acc_res_rdy = 1'b1;
        end else begin
            while (byte_cnt < base + NBYTES) @(negedge clk);
            acc_req = 1'b0;
            acc_res_rdy = 1'b1;
        end
        @(negedge clk);
        chk(acc_give == 1'b1, "R5", "fetch pulse", acc_give, 1);
        chk(state == 2'd3, "R5", "drain state", state, 3);
        if (mode == 2)
            chk(byte_cnt == base + NBYTES, "R11", "byte at results-ready", byte_cnt - base, NBYTES);
        acc_req = 1'b0;
        acc_res_rdy = 1'b0;
        @(negedge clk);
        chk(acc_give == 1'b0, "R5", "fetch pulse width", acc_give, 0);
        rbase = res_cnt;
        for (int k = 0; k < NRES; k++) begin
            exp_res.push_back({img[7:0], s[7:0], k[15:0]});
            tries = 0;
            do begin
                if (tries > 0) @(negedge clk);
                acc_res_vld = 1'b1;
                acc_res = {img[7:0], s[7:0], k[15:0]};
                out_full = (k == 1 && tries < 2);
                if (k == NRES - 1 && mode == 3) begin
                    acc_seg_done = 1'b1;
                    acc_img_done = last_seg;
                end
                #1;
                took = acc_res_take;
                if (out_full) chk(!took, "R6", "take while full", took, 0);
                tries++;
            end while (!took);
            @(negedge clk);
        end
        acc_res_vld = 1'b0;
        out_full = 1'b0;
        if (mode != 3) begin
            acc_seg_done = 1'b1;
            acc_img_done = last_seg;
            @(negedge clk);
        end
        acc_seg_done = 1'b0;
        acc_img_done = 1'b0;
        if (mode == 3)
            chk(res_cnt == rbase + NRES, "R11", "result with segment-done", res_cnt - rbase, NRES);
        else
            chk(res_cnt == rbase + NRES, "R6", "results per segment", res_cnt - rbase, NRES);
        if (last_seg) begin
            chk(state == 2'd0, "R8", "image end state", state, 0);
            chk(seg_idx == 4'd0, "R8", "image end index", seg_idx, 0);
        end else begin
            chk(state == 2'd1, "R7", "next segment state", state, 1);
            chk(seg_idx == s[3:0] + 4'd1, "R7", "next segment index", seg_idx, s + 1);
        end
    endtask

    task automatic run_image(input int img);
        int mode;
        acc_ready = 1'b1;
        @(negedge clk);
        chk(acc_start == 1'b1, "R2", "start pulse", acc_start, 1);
        chk(state == 2'd1, "R10", "state after start", state, 1);
        @(negedge clk);
        chk(acc_start == 1'b0, "R2", "start pulse width", acc_start, 0);
        for (int s = 0; s < SEGS; s++) begin
            if (s == 2) mode = 1;
            else if (s == 5) mode = 2;
            else if (s == 7) mode = 3;
            else if (s == SEGS - 1 && img == 0) mode = 3;
            else mode = 0;
            run_seg(img, s, mode);
        end
    endtask

    // Driver: reset, two images, final counts.
    initial begin
        rst_n = 1'b0;
        acc_ready = 1'b1;
        repeat (3) @(negedge clk);
        chk(state == 2'd0, "R1", "reset state", state, 0);
        chk(seg_idx == 4'd0, "R1", "reset index", seg_idx, 0);
        chk(!acc_start && !acc_give, "R1", "no pulse in reset", {acc_start, acc_give}, 0);
        chk(!in_pop && !out_push, "R1", "no transfer in reset", {in_pop, out_push}, 0);
        acc_ready = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(state == 2'd0 && !acc_start, "R1", "idle after reset", state, 0);
        run_image(0);
        repeat (3) @(negedge clk);
        chk(state == 2'd0 && n_start == 1, "R2", "no start without ready", n_start, 1);
        run_image(1);
        repeat (2) @(negedge clk);
        chk(n_start == 2, "R2", "start count", n_start, 2);
        chk(n_give == 2 * SEGS, "R5", "fetch count", n_give, 2 * SEGS);
        chk(exp_bytes.size() == 0, "R3", "bytes left", exp_bytes.size(), 0);
        chk(exp_res.size() == 0, "R6", "results left", exp_res.size(), 0);
        finish_up();
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG);
        finish_up();
    end

endmodule